// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It is a set-associative cache of branch targets. The front end presents a branch address, a global history value and a snapshot of the most recent indirect-branch targets. The block folds these into a set index and derives a partial tag from the branch address. It searches every way of the indexed set and returns a hit flag and a predicted target one cycle later. When the branch resolves, the back end presents the same address, history and path snapshot together with the real target. The block then either refreshes the target of the way whose tag matches, or claims a way chosen by a free-running LFSR.

Lookups use a valid/ready request channel and a valid/ready response channel. The response register is a single stage. A new request is accepted when that register is empty, or when it is being drained in the same cycle (`lk_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds unchanged. Updates are a plain strobe and are accepted every cycle. A lookup in the same cycle as an update sees the contents as they were before that update. The path snapshot is held outside the block: entry 0 is the newest target, and `*_path_cnt` says how many entries are valid.

Top module: `tgtp_top`

## Requirements
- R1: After reset `rsp_valid` is 0, `lk_ready` is 1, and every way is invalid, so any lookup misses.
- R2: The set index is computed in three steps. Start with `addr >> INST_SHIFT`. XOR in `ghr` when HASH_GHR is 1. When HASH_TGT is 1, XOR in, for each age p below `path_cnt`, path entry p shifted right by `INST_SHIFT + p*(log2(SETS)/PATH_LEN)`. Finally keep the low log2(SETS) bits. With the defaults (SETS=16, PATH_LEN=2, INST_SHIFT=2) the shifts are 2 for age 0 and 4 for age 1.
- R3: The tag is the low TAG_W bits of `addr >> INST_SHIFT`. A lookup hits only on a valid way of the indexed set whose tag is equal, and a differing tag misses.
- R4: A lookup accepted on a clock edge presents `rsp_valid`, `rsp_hit` and `rsp_target` after exactly that edge; on a hit, the target is the one stored in the first matching way.
- R5: An update whose tag matches a valid way in the indexed set overwrites only that way's target, and a later lookup returns the new target.
- R6: An update with no match writes tag and target into way `lfsr mod WAYS` and sets its valid bit. The entry just written always hits next. A set never holds more than WAYS distinct tags.
- R7: `lk_ready` is 0 while a response waits with `rsp_ready` low, and the waiting response holds its hit and target stable until taken.
- R8: Path entries at ages at or above `path_cnt` have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_ghr | input | GHR_W | Global history for lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent targets, entry 0 newest in low bits |
| lk_path_cnt | input | clog2(PATH_LEN+1) | Valid path entries for lookup |
| rsp_valid | output | 1 | Prediction valid |
| rsp_ready | input | 1 | Prediction consumed |
| rsp_hit | output | 1 | Predicted target found |
| rsp_target | output | ADDR_W | Predicted target |
| upd_valid | input | 1 | Training strobe |
| upd_addr | input | ADDR_W | Resolved branch address |
| upd_ghr | input | GHR_W | Global history for update |
| upd_path | input | PATH_LEN*ADDR_W | Recent targets for update |
| upd_path_cnt | input | clog2(PATH_LEN+1) | Valid path entries for update |
| upd_target | input | ADDR_W | Resolved target |

## Verification
The hardest situation to reach is more distinct tags than ways competing for one set. The LFSR position cannot be seen at the ports, and the hash scatters ordinary addresses across sets. The stimulus solves the hash by hand: it keeps history and path count at zero and steps the shifted address in multiples of SETS. Every address then lands in one set with a different tag. Seven such entries are written, each checked to hit straight away, and the survivors are counted against the way count.

// File: rtl/tgtp_pkg.sv
package tgtp_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/tgtp_hash.sv
module tgtp_hash #(
  parameter int ADDR_W     = 32,
  parameter int GHR_W      = 8,
  parameter int SETS       = 16,
  parameter int TAG_W      = 8,
  parameter int PATH_LEN   = 2,
  parameter int INST_SHIFT = 2,
  parameter bit HASH_GHR   = 1'b1,
  parameter bit HASH_TGT   = 1'b1,
  localparam int IDX_W     = $clog2(SETS),
  localparam int CNT_W     = $clog2(PATH_LEN + 1)
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [GHR_W-1:0]           ghr,
  input  logic [PATH_LEN*ADDR_W-1:0] path,
  input  logic [CNT_W-1:0]           path_cnt,
  output logic [IDX_W-1:0]           idx,
  output logic [TAG_W-1:0]           tag
);
  localparam int AGE_STEP = IDX_W / PATH_LEN;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] terms [PATH_LEN];
  logic [ADDR_W-1:0] folded;

  assign base = addr >> INST_SHIFT;

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_age
    assign terms[p] = (HASH_TGT && (p < int'(path_cnt)))
                    ? (path[p*ADDR_W +: ADDR_W] >> (INST_SHIFT + p*AGE_STEP))
                    : '0;
  end

  always_comb begin
    folded = base;
    if (HASH_GHR) folded = folded ^ ADDR_W'(ghr);
    for (int p = 0; p < PATH_LEN; p++) folded = folded ^ terms[p];
  end

  assign idx = folded[IDX_W-1:0];
  assign tag = base[TAG_W-1:0];

  logic unused_hash;
  assign unused_hash = ^{folded[ADDR_W-1:IDX_W], base[ADDR_W-1:TAG_W]};
endmodule

// File: rtl/tgtp_lfsr.sv
module tgtp_lfsr
  import tgtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= lfsr_step(state);
  end
endmodule

// File: rtl/tgtp_store.sv
module tgtp_store #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [WAY_W-1:0]  wr_rand_way
);
  logic              valid_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q   [SETS][WAYS];

  logic [WAYS-1:0] rd_match, wr_match;
  logic            wr_hit;
  logic [WAY_W-1:0] wr_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign rd_match[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
    assign wr_match[w] = valid_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
  end

  always_comb begin
    rd_hit    = 1'b0;
    rd_target = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rd_match[w]) begin
        rd_hit    = 1'b1;
        rd_target = tgt_q[rd_idx][w];
      end
    end
  end

  always_comb begin
    wr_hit = 1'b0;
    wr_way = wr_rand_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wr_match[w]) begin
        wr_hit = 1'b1;
        wr_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) valid_q[s][w] <= 1'b0;
    end else if (wr_en && !wr_hit) begin
      valid_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tgt_q[wr_idx][wr_way] <= wr_target;
      if (!wr_hit) tag_q[wr_idx][wr_way] <= wr_tag;
    end
  end
endmodule

// File: rtl/tgtp_top.sv
module tgtp_top
  import tgtp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GHR_W      = 8,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 8,
  parameter int PATH_LEN   = 2,
  parameter int INST_SHIFT = 2,
  parameter bit HASH_GHR   = 1'b1,
  parameter bit HASH_TGT   = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lk_valid,
  output logic                             lk_ready,
  input  logic [ADDR_W-1:0]                lk_addr,
  input  logic [GHR_W-1:0]                 lk_ghr,
  input  logic [PATH_LEN*ADDR_W-1:0]       lk_path,
  input  logic [$clog2(PATH_LEN+1)-1:0]    lk_path_cnt,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic                             rsp_hit,
  output logic [ADDR_W-1:0]                rsp_target,
  input  logic                             upd_valid,
  input  logic [ADDR_W-1:0]                upd_addr,
  input  logic [GHR_W-1:0]                 upd_ghr,
  input  logic [PATH_LEN*ADDR_W-1:0]       upd_path,
  input  logic [$clog2(PATH_LEN+1)-1:0]    upd_path_cnt,
  input  logic [ADDR_W-1:0]                upd_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              rd_hit;
  logic [ADDR_W-1:0] rd_target;
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  rand_way;
  logic              accept;

  tgtp_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .SETS(SETS), .TAG_W(TAG_W),
    .PATH_LEN(PATH_LEN), .INST_SHIFT(INST_SHIFT),
    .HASH_GHR(HASH_GHR), .HASH_TGT(HASH_TGT)
  ) u_hash_lk (
    .addr(lk_addr), .ghr(lk_ghr), .path(lk_path), .path_cnt(lk_path_cnt),
    .idx(lk_idx), .tag(lk_tag)
  );

  tgtp_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .SETS(SETS), .TAG_W(TAG_W),
    .PATH_LEN(PATH_LEN), .INST_SHIFT(INST_SHIFT),
    .HASH_GHR(HASH_GHR), .HASH_TGT(HASH_TGT)
  ) u_hash_up (
    .addr(upd_addr), .ghr(upd_ghr), .path(upd_path), .path_cnt(upd_path_cnt),
    .idx(up_idx), .tag(up_tag)
  );

  tgtp_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  assign rand_way = WAY_W'(int'(lfsr_q) % WAYS);

  tgtp_store #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(rd_hit), .rd_target(rd_target),
    .wr_en(upd_valid), .wr_idx(up_idx), .wr_tag(up_tag),
    .wr_target(upd_target), .wr_rand_way(rand_way)
  );

  assign lk_ready = !rsp_valid || rsp_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= rd_hit;
      rsp_target <= rd_target;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tgtp_checker.sv
module tgtp_checker #(
  parameter int ADDR_W = 32,
  parameter int LW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_target,
  input logic [LW-1:0]     lfsr_q
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R4

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lk_valid && lk_ready) && !rsp_valid) |=> !rsp_valid); // R4

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_target))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready); // R7

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (lfsr_q != '0)); // R6
endmodule

bind tgtp_top tgtp_checker #(.ADDR_W(ADDR_W), .LW(tgtp_pkg::LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_target(rsp_target), .lfsr_q(lfsr_q)
);

// File: tb/tgtp_top_test.sv
`timescale 1ns/1ps
module tgtp_top_test;
  localparam int AW = 32;
  localparam int GW = 8;
  localparam int PL = 2;
  localparam int CW = 2;
  localparam int WAYS = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic lk_valid = 0, lk_ready;
  logic [AW-1:0] lk_addr = '0;
  logic [GW-1:0] lk_ghr = '0;
  logic [PL*AW-1:0] lk_path = '0;
  logic [CW-1:0] lk_path_cnt = '0;
  logic rsp_valid, rsp_ready = 1, rsp_hit;
  logic [AW-1:0] rsp_target;
  logic upd_valid = 0;
  logic [AW-1:0] upd_addr = '0, upd_target = '0;
  logic [GW-1:0] upd_ghr = '0;
  logic [PL*AW-1:0] upd_path = '0;
  logic [CW-1:0] upd_path_cnt = '0;

  always #2 clk = ~clk;

  tgtp_top uut (.*);

  typedef struct {
    logic          hit;
    logic [AW-1:0] tgt;
    bit            exact;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0, errors = 0, dc_hits = 0;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Monitor: compares each response as it is handed over
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.exact) begin
          check(rsp_hit == e.hit, e.req, "hit", rsp_hit, e.hit);
          if (e.hit) check(rsp_target == e.tgt, e.req, "target", rsp_target, e.tgt);
        end else if (rsp_hit) begin
          dc_hits++;
          check(rsp_target == e.tgt, e.req, "survivor target", rsp_target, e.tgt);
        end
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input logic [GW-1:0] g,
                        input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                        input int cnt, input logic eh, input logic [AW-1:0] et,
                        input bit exact, input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_ghr = g; lk_path = {p1, p0};
    lk_path_cnt = CW'(cnt);
    e.hit = eh; e.tgt = et; e.exact = exact; e.req = req;
    exp_q.push_back(e);
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic update(input logic [AW-1:0] a, input logic [GW-1:0] g,
                        input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                        input int cnt, input logic [AW-1:0] t);
    @(negedge clk);
    upd_valid = 1; upd_addr = a; upd_ghr = g; upd_path = {p1, p0};
    upd_path_cnt = CW'(cnt); upd_target = t;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [AW-1:0] A = 32'h0000_1040;
  localparam logic [AW-1:0] B = 32'h0000_1080; // same set as A, other tag
  localparam logic [AW-1:0] C = 32'h0000_4000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state
    check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(lk_ready == 1, "R1", "lk_ready after reset", lk_ready, 1);
    @(negedge clk); rst_n = 1;
    lookup(A, 0, 0, 0, 0, 0, 0, 1, "R1");
    drain();

    // R6 allocate, R4 result
    update(A, 0, 0, 0, 0, 32'h2000);
    lookup(A, 0, 0, 0, 0, 1, 32'h2000, 1, "R6");
    // R5 overwrite on match
    update(A, 0, 0, 0, 0, 32'h3000);
    lookup(A, 0, 0, 0, 0, 1, 32'h3000, 1, "R5");
    // R3 different tag in same set misses
    lookup(B, 0, 0, 0, 0, 0, 0, 1, "R3");
    // R2 history moves the set
    lookup(A, 8'h01, 0, 0, 0, 0, 0, 1, "R2");
    update(A, 8'h05, 0, 0, 0, 32'h5000);
    lookup(A, 8'h05, 0, 0, 0, 1, 32'h5000, 1, "R2");
    lookup(A, 0, 0, 0, 0, 1, 32'h3000, 1, "R2");
    // R2 path folding: age0 shift 2, age1 shift 4
    update(C, 0, 32'h100, 32'h880, 2, 32'h6000);
    lookup(C, 0, 32'h100, 32'h880, 2, 1, 32'h6000, 1, "R2");
    lookup(C, 0, 32'h100, 32'h890, 2, 0, 0, 1, "R2");
    lookup(C, 0, 32'h104, 32'h880, 2, 0, 0, 1, "R2");
    // R8 entries beyond the count are ignored
    update(C + 32'h400, 0, 32'h20, 32'h0, 1, 32'h7000);
    lookup(C + 32'h400, 0, 32'h20, 32'hFFF0, 1, 1, 32'h7000, 1, "R8");
    drain();

    // R7 back-pressure, R4 latency
    @(negedge clk); rsp_ready = 0;
    lookup(A, 0, 0, 0, 0, 1, 32'h3000, 1, "R7");
    #1;
    check(rsp_valid == 1, "R4", "valid one cycle after accept", rsp_valid, 1);
    check(lk_ready == 0, "R7", "lk_ready during stall", lk_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 1 && rsp_target == 32'h3000, "R7", "held target",
          rsp_target, 32'h3000);
    @(negedge clk); rsp_ready = 1;
    drain();

    // R6 eviction: seven tags into one set of four ways
    for (int k = 0; k < 7; k++) begin
      logic [AW-1:0] a;
      a = (32'h0803 + 32'(k) * 32'h10) << 2;
      update(a, 0, 0, 0, 0, 32'h9000 + 32'(k));
      lookup(a, 0, 0, 0, 0, 1, 32'h9000 + 32'(k), 1, "R6");
    end
    drain();
    dc_hits = 0;
    for (int k = 0; k < 7; k++) begin
      logic [AW-1:0] a;
      a = (32'h0803 + 32'(k) * 32'h10) << 2;
      lookup(a, 0, 0, 0, 0, 1, 32'h9000 + 32'(k), 0, "R6");
    end
    drain();
    check(dc_hits <= WAYS && dc_hits >= 1, "R6", "survivors in set", dc_hits, WAYS);
    finish_run();
  end
endmodule